// File: doc/BRIEF.md
# Parity-Synchronised Mailbox Command Engine

This engine sits on the host side of a mailbox of 16-bit registers and carries commands to an embedded controller. Software gives it an operation, a 6-bit opcode, a byte length and up to eight payload words. It copies the payload into the mailbox data registers, writes a command word, and then polls the status register until the controller finishes or the poll budget runs out. Commands are kept in order by a single parity bit. The engine holds that bit, places it in every command word, and flips it after each command write.

The engine can also read reply words back, using the length and code held in the last captured status word. It can run a resynchronisation sequence that brings its parity back into line with the controller. Only one operation runs at a time. `busy_o` stays high while the operation runs. A one-cycle `done_o` pulse ends it and comes with an error code and the captured status word. All mailbox traffic uses a simple request/acknowledge register bus.

Top module: `ipc_cmd_engine`

## Requirements
- R1: The command word is written to address 0x5801. It carries the parity in bit 15, the byte length in bits 10:6 and the opcode in bits 5:0. Bits 14:11 are zero.
- R2: In send and post operations, floor(length/2) payload words are written first. Word k goes to address 0x5808+k. The command word follows.
- R3: The stored parity is 0 after reset and inverts on every accepted command write.
- R4: After a command write (op 0), status at 0x5802 is read once every POLL_GAP cycles. The wait ends only when status bit 15 equals the parity just sent and the code in bits 3:0 is not 0x1, 0x2 or 0xE.
- R5: A finished command reports error 0 if the final code is 0x4 and error 3 (fault) for any other code. The final status word appears on `status_o`.
- R6: An op-0 or op-1 request with a length above 16 ends with error 1. It makes no bus access and leaves the parity unchanged.
- R7: If POLL_LIMIT status reads all show the command unfinished, the operation ends with error 2 (timeout) after exactly POLL_LIMIT reads.
- R8: Op 1 (post) writes the command and finishes with error 0 without reading status.
- R9: Op 2 (read reply) reads ceil(L/2) words from 0x5808 upward, where L is bits 14:10 of the last captured status. Word k appears on `reply_o[16k+15:16k]`, the unused words read zero, and `reply_cnt_o` gives the count.
- R10: Op 2 ends with error 3 if the captured code is 0x8. Otherwise it ends with error 1 if L exceeds 16. In both cases it makes no bus access.
- R11: Op 3 (resync) first writes a NOP command word with the current parity and opcode 0, length 0, and does not wait. It then forces the parity to 0, writes a second NOP with parity 0 and waits for completion. It ends with error 0 only if the final code is 0xF, and with error 4 otherwise. The stored parity is 1 afterwards.
- R12: After reset `busy_o`, `done_o` and `bus_req_o` are low. `done_o` is never high together with `busy_o`, and `bus_req_o` is only high while busy.
- R13: A bus request holds its address, direction and write data steady until the cycle in which `bus_ack_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (taken when idle) |
| op_i | input | 2 | 0 send+wait, 1 post, 2 read reply, 3 resync |
| opcode_i | input | 6 | Command opcode |
| len_i | input | 6 | Payload length in bytes |
| payload_i | input | 128 | Eight payload words, word k in bits 16k+15:16k |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 3 | 0 none, 1 length, 2 timeout, 3 fault, 4 sync failure |
| status_o | output | 16 | Last captured status word |
| reply_o | output | 128 | Reply words from the last read |
| reply_cnt_o | output | 4 | Number of reply words read |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | Bus write enable |
| bus_addr_o | output | 16 | Bus address |
| bus_wdata_o | output | 16 | Bus write data |
| bus_rdata_i | input | 16 | Bus read data, valid with acknowledge |
| bus_ack_i | input | 1 | Bus acknowledge |

## Verification
The bench sweeps every length from 0 to 18 and every 4-bit status code. An engine that miscounted payload words, allowed a length of 17 onto the bus, or treated a transient code as final would show a wrong write count, stray traffic, or the wrong error or number of polls. The mailbox model first returns stale-parity "success" replies and then transient codes. An engine that compared only the code would finish early, with too few status reads. Reply reads are swept over every reported length, including odd lengths where rounding down would drop a word. Resync is run starting from both parity values, and the parity of the following command is checked. An engine that forgot to force or flip the parity would place the wrong bit 15 in the next command.

// File: rtl/ipc_eng_pkg.sv
package ipc_eng_pkg;
  typedef enum logic [1:0] {OP_SEND = 2'd0, OP_POST = 2'd1, OP_READ = 2'd2, OP_SYNC = 2'd3} op_e;
  typedef enum logic [2:0] {E_NONE = 3'd0, E_LEN = 3'd1, E_TIMEOUT = 3'd2, E_FAULT = 3'd3, E_SYNC = 3'd4} err_e;
  typedef enum logic [2:0] {S_IDLE, S_WDATA, S_WCMD, S_GAP, S_RSTS, S_RREP} fsm_e;
  localparam logic [3:0] CODE_RCVD  = 4'h1;
  localparam logic [3:0] CODE_PROC  = 4'h2;
  localparam logic [3:0] CODE_OK    = 4'h4;
  localparam logic [3:0] CODE_ERR   = 4'h8;
  localparam logic [3:0] CODE_BUSY  = 4'hE;
  localparam logic [3:0] CODE_READY = 4'hF;
endpackage

// File: rtl/ipc_word_codec.sv
module ipc_word_codec
  import ipc_eng_pkg::*;
(
  input  logic        par_i,
  input  logic [4:0]  len_i,
  input  logic [5:0]  opcode_i,
  input  logic [15:0] sts_i,
  input  logic        exp_par_i,
  output logic [15:0] cmd_o,
  output logic [4:0]  sts_len_o,
  output logic [3:0]  sts_code_o,
  output logic        sts_final_o
);
  logic transient;

  assign cmd_o      = {par_i, 4'b0000, len_i, opcode_i};
  assign sts_len_o  = sts_i[14:10];
  assign sts_code_o = sts_i[3:0];
  assign transient  = (sts_code_o == CODE_RCVD) || (sts_code_o == CODE_PROC) ||
                      (sts_code_o == CODE_BUSY);
  assign sts_final_o = (sts_i[15] == exp_par_i) && !transient;
endmodule

// File: rtl/ipc_poll_timer.sv
module ipc_poll_timer #(
  parameter int GAP   = 4,
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic clr_i,
  input  logic inc_i,
  output logic gap_done_o,
  output logic last_o
);
  localparam int GW = $clog2(GAP + 1);
  localparam int PW = $clog2(LIMIT + 1);

  logic [GW-1:0] gcnt_q, gcnt_d;
  logic          run_q, run_d;
  logic [PW-1:0] pcnt_q, pcnt_d;

  always_comb begin
    gcnt_d = gcnt_q;
    run_d  = run_q;
    if (arm_i) begin
      gcnt_d = GW'(GAP - 1);
      run_d  = 1'b1;
    end else if (run_q) begin
      if (gcnt_q == '0) run_d = 1'b0;
      else              gcnt_d = gcnt_q - 1'b1;
    end
    pcnt_d = pcnt_q;
    if (clr_i)      pcnt_d = '0;
    else if (inc_i) pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt_q <= '0;
      run_q  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      gcnt_q <= gcnt_d;
      run_q  <= run_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign gap_done_o = run_q && (gcnt_q == '0);
  assign last_o     = (pcnt_q == PW'(LIMIT - 1));
endmodule

// File: rtl/ipc_cmd_engine.sv
module ipc_cmd_engine
  import ipc_eng_pkg::*;
#(
  parameter int          WORD_W    = 16,
  parameter int          DATA_REGS = 8,
  parameter int          LEN_W     = 6,
  parameter int          ADDR_W    = 16,
  parameter int          POLL_GAP  = 16,
  parameter int          POLL_LIMIT = 100,
  parameter logic [15:0] CMD_ADDR  = 16'h5801,
  parameter logic [15:0] STS_ADDR  = 16'h5802,
  parameter logic [15:0] DATA_BASE = 16'h5808
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [1:0]                  op_i,
  input  logic [5:0]                  opcode_i,
  input  logic [LEN_W-1:0]            len_i,
  input  logic [DATA_REGS*WORD_W-1:0] payload_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [2:0]                  err_o,
  output logic [WORD_W-1:0]           status_o,
  output logic [DATA_REGS*WORD_W-1:0] reply_o,
  output logic [$clog2(DATA_REGS+1)-1:0] reply_cnt_o,
  output logic                        bus_req_o,
  output logic                        bus_we_o,
  output logic [ADDR_W-1:0]           bus_addr_o,
  output logic [WORD_W-1:0]           bus_wdata_o,
  input  logic [WORD_W-1:0]           bus_rdata_i,
  input  logic                        bus_ack_i
);
  localparam int IDX_W     = $clog2(DATA_REGS + 1);
  localparam int SEL_W     = $clog2(DATA_REGS);
  localparam int MAX_BYTES = DATA_REGS * 2;

  fsm_e              state_q, state_d;
  op_e               op_q, op_d;
  logic [5:0]        opc_q, opc_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [WORD_W-1:0] pay_q [DATA_REGS];
  logic [WORD_W-1:0] pay_d [DATA_REGS];
  logic [WORD_W-1:0] rep_q [DATA_REGS];
  logic [WORD_W-1:0] rep_d [DATA_REGS];
  logic [IDX_W-1:0]  idx_q, idx_d, nw_q, nw_d, rcnt_q, rcnt_d;
  logic              par_q, par_d, sent_q, sent_d, sync_q, sync_d;
  logic [WORD_W-1:0] sts_q, sts_d;
  logic              done_q, done_d;
  err_e              err_q, err_d;

  logic        poll_arm, poll_clr, poll_inc, gap_done, poll_last;
  logic [15:0] cmd_word, dec_word;
  logic [4:0]  dec_len;
  logic [3:0]  dec_code;
  logic        dec_final;
  logic [IDX_W-1:0] idx_inc;

  assign dec_word = (state_q == S_RSTS) ? bus_rdata_i : sts_q;
  assign idx_inc  = idx_q + 1'b1;

  ipc_word_codec u_codec (
    .par_i      (par_q),
    .len_i      (len_q[4:0]),
    .opcode_i   (opc_q),
    .sts_i      (dec_word),
    .exp_par_i  (sent_q),
    .cmd_o      (cmd_word),
    .sts_len_o  (dec_len),
    .sts_code_o (dec_code),
    .sts_final_o(dec_final)
  );

  ipc_poll_timer #(.GAP(POLL_GAP), .LIMIT(POLL_LIMIT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (poll_arm),
    .clr_i     (poll_clr),
    .inc_i     (poll_inc),
    .gap_done_o(gap_done),
    .last_o    (poll_last)
  );

  always_comb begin
    state_d = state_q; op_d = op_q; opc_d = opc_q; len_d = len_q;
    pay_d = pay_q; rep_d = rep_q;
    idx_d = idx_q; nw_d = nw_q; rcnt_d = rcnt_q;
    par_d = par_q; sent_d = sent_q; sync_d = sync_q;
    sts_d = sts_q; err_d = err_q; done_d = 1'b0;
    poll_arm = 1'b0; poll_clr = 1'b0; poll_inc = 1'b0;
    case (state_q)
      S_IDLE: if (start_i) begin
        op_d = op_e'(op_i); opc_d = opcode_i; len_d = len_i;
        idx_d = '0; sync_d = 1'b0;
        for (int k = 0; k < DATA_REGS; k++) pay_d[k] = payload_i[k*WORD_W +: WORD_W];
        case (op_e'(op_i))
          OP_SEND, OP_POST: begin
            if (len_i > LEN_W'(MAX_BYTES)) begin
              done_d = 1'b1; err_d = E_LEN;
            end else begin
              nw_d = IDX_W'(len_i >> 1);
              state_d = ((len_i >> 1) != '0) ? S_WDATA : S_WCMD;
            end
          end
          OP_READ: begin
            for (int k = 0; k < DATA_REGS; k++) rep_d[k] = '0;
            rcnt_d = '0;
            if (dec_code == CODE_ERR) begin
              done_d = 1'b1; err_d = E_FAULT;
            end else if (6'(dec_len) > 6'(MAX_BYTES)) begin
              done_d = 1'b1; err_d = E_LEN;
            end else if (dec_len == '0) begin
              done_d = 1'b1; err_d = E_NONE;
            end else begin
              nw_d = IDX_W'((6'(dec_len) + 6'd1) >> 1);
              state_d = S_RREP;
            end
          end
          default: begin
            opc_d = '0; len_d = '0; state_d = S_WCMD;
          end
        endcase
      end
      S_WDATA: if (bus_ack_i) begin
        idx_d = idx_inc;
        if (idx_inc == nw_q) state_d = S_WCMD;
      end
      S_WCMD: if (bus_ack_i) begin
        sent_d = par_q;
        par_d  = ~par_q;
        if (op_q == OP_SYNC && !sync_q) begin
          par_d = 1'b0; sync_d = 1'b1;
        end else if (op_q == OP_POST) begin
          state_d = S_IDLE; done_d = 1'b1; err_d = E_NONE;
        end else begin
          poll_arm = 1'b1; poll_clr = 1'b1; state_d = S_GAP;
        end
      end
      S_GAP: if (gap_done) state_d = S_RSTS;
      S_RSTS: if (bus_ack_i) begin
        sts_d = bus_rdata_i;
        poll_inc = 1'b1;
        if (dec_final) begin
          state_d = S_IDLE; done_d = 1'b1;
          if (op_q == OP_SYNC) err_d = (dec_code == CODE_READY) ? E_NONE : E_SYNC;
          else                 err_d = (dec_code == CODE_OK) ? E_NONE : E_FAULT;
        end else if (poll_last) begin
          state_d = S_IDLE; done_d = 1'b1; err_d = E_TIMEOUT;
        end else begin
          poll_arm = 1'b1; state_d = S_GAP;
        end
      end
      S_RREP: if (bus_ack_i) begin
        rep_d[idx_q[SEL_W-1:0]] = bus_rdata_i;
        idx_d = idx_inc; rcnt_d = idx_inc;
        if (idx_inc == nw_q) begin
          state_d = S_IDLE; done_d = 1'b1; err_d = E_NONE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; op_q <= OP_SEND; opc_q <= '0; len_q <= '0;
      for (int k = 0; k < DATA_REGS; k++) begin
        pay_q[k] <= '0;
        rep_q[k] <= '0;
      end
      idx_q <= '0; nw_q <= '0; rcnt_q <= '0;
      par_q <= 1'b0; sent_q <= 1'b0; sync_q <= 1'b0;
      sts_q <= '0; err_q <= E_NONE; done_q <= 1'b0;
    end else begin
      state_q <= state_d; op_q <= op_d; opc_q <= opc_d; len_q <= len_d;
      pay_q <= pay_d; rep_q <= rep_d;
      idx_q <= idx_d; nw_q <= nw_d; rcnt_q <= rcnt_d;
      par_q <= par_d; sent_q <= sent_d; sync_q <= sync_d;
      sts_q <= sts_d; err_q <= err_d; done_q <= done_d;
    end
  end

  always_comb begin
    bus_req_o   = 1'b0;
    bus_we_o    = 1'b0;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    case (state_q)
      S_WDATA: begin
        bus_req_o = 1'b1; bus_we_o = 1'b1;
        bus_addr_o  = DATA_BASE + ADDR_W'(idx_q);
        bus_wdata_o = pay_q[idx_q[SEL_W-1:0]];
      end
      S_WCMD: begin
        bus_req_o = 1'b1; bus_we_o = 1'b1;
        bus_addr_o = CMD_ADDR; bus_wdata_o = cmd_word;
      end
      S_RSTS: begin
        bus_req_o = 1'b1; bus_addr_o = STS_ADDR;
      end
      S_RREP: begin
        bus_req_o = 1'b1; bus_addr_o = DATA_BASE + ADDR_W'(idx_q);
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < DATA_REGS; g++) begin : g_reply
    assign reply_o[g*WORD_W +: WORD_W] = rep_q[g];
  end

  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign status_o    = sts_q;
  assign reply_cnt_o = rcnt_q;
endmodule

// File: rtl/ipc_cmd_engine_chk.sv
module ipc_cmd_engine_chk #(
  parameter int          ADDR_W    = 16,
  parameter int          WORD_W    = 16,
  parameter int          DATA_REGS = 8,
  parameter logic [15:0] CMD_ADDR  = 16'h5801,
  parameter logic [15:0] STS_ADDR  = 16'h5802,
  parameter logic [15:0] DATA_BASE = 16'h5808
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [WORD_W-1:0] bus_wdata_o,
  input logic              bus_ack_i
);
  logic in_data;
  assign in_data = (bus_addr_o >= ADDR_W'(DATA_BASE)) &&
                   (bus_addr_o < ADDR_W'(DATA_BASE) + ADDR_W'(DATA_REGS));

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R12
  start_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o || done_o));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bus_req_o);

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) &&
                                   $stable(bus_we_o) && $stable(bus_wdata_o)));

  // R2
  wr_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_we_o) |-> (bus_addr_o == ADDR_W'(CMD_ADDR) || in_data));

  // R4
  rd_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_we_o) |-> (bus_addr_o == ADDR_W'(STS_ADDR) || in_data));
endmodule

bind ipc_cmd_engine ipc_cmd_engine_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .DATA_REGS(DATA_REGS),
  .CMD_ADDR(CMD_ADDR), .STS_ADDR(STS_ADDR), .DATA_BASE(DATA_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
  .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i)
);

// File: tb/sim_ipc_cmd_engine.sv
module sim_ipc_cmd_engine;
  localparam int GAP = 3;
  localparam int LIM = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         start = 1'b0;
  logic [1:0]   op = 2'd0;
  logic [5:0]   opc = 6'd0;
  logic [5:0]   len = 6'd0;
  logic [127:0] pay = '0;
  logic         busy, done;
  logic [2:0]   err;
  logic [15:0]  sts;
  logic [127:0] rep;
  logic [3:0]   rcnt;
  logic         req, we;
  logic [15:0]  addr, wdata;
  logic [15:0]  rdata;
  logic         ack;

  ipc_cmd_engine #(.POLL_GAP(GAP), .POLL_LIMIT(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .opcode_i(opc),
    .len_i(len), .payload_i(pay), .busy_o(busy), .done_o(done), .err_o(err),
    .status_o(sts), .reply_o(rep), .reply_cnt_o(rcnt), .bus_req_o(req),
    .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
    .bus_rdata_i(rdata), .bus_ack_i(ack)
  );

  // mailbox model
  logic       log_clr = 1'b0;
  int         cfg_stale = 0, cfg_busy = 0;
  logic       cfg_hang = 1'b0;
  logic [3:0] cfg_code = 4'h4;
  logic [4:0] cfg_rlen = 5'd0;
  logic [15:0] cmd_log [4];
  logic [15:0] dmem [8];
  int   ncmd, nwr, nsts, nrd, stale_left, busy_left;
  logic cur_par;
  logic [5:0] cur_op;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0; rdata <= '0; ncmd <= 0; nwr <= 0; nsts <= 0; nrd <= 0;
      stale_left <= 0; busy_left <= 0; cur_par <= 1'b0; cur_op <= '0;
    end else if (log_clr) begin
      ack <= 1'b0; ncmd <= 0; nwr <= 0; nsts <= 0; nrd <= 0;
    end else if (req && !ack) begin
      ack <= 1'b1;
      if (we) begin
        if (addr == 16'h5801) begin
          if (ncmd < 4) cmd_log[ncmd] <= wdata;
          ncmd <= ncmd + 1;
          cur_par <= wdata[15]; cur_op <= wdata[5:0];
          stale_left <= cfg_stale; busy_left <= cfg_busy;
        end else begin
          dmem[addr[2:0]] <= wdata;
          nwr <= nwr + 1;
        end
      end else if (addr == 16'h5802) begin
        nsts <= nsts + 1;
        if (cfg_hang) rdata <= {cur_par, 5'd0, cur_op, 4'hE};
        else if (stale_left > 0) begin
          rdata <= {~cur_par, cfg_rlen, cur_op, 4'h4};
          stale_left <= stale_left - 1;
        end else if (busy_left > 0) begin
          rdata <= {cur_par, 5'd0, cur_op, (busy_left % 3 == 0) ? 4'h1 :
                                            (busy_left % 3 == 1) ? 4'h2 : 4'hE};
          busy_left <= busy_left - 1;
        end else rdata <= {cur_par, cfg_rlen, cur_op, cfg_code};
      end else begin
        nrd <= nrd + 1;
        rdata <= 16'hC300 + 16'(addr - 16'h5808) * 16'h0011;
      end
    end else ack <= 1'b0;
  end

  int total = 0, bad = 0;
  logic exp_par = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] o, input logic [5:0] oc, input logic [5:0] ln);
    int n;
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
    start = 1'b1; op = o; opc = oc; len = ln;
    for (int k = 0; k < 8; k++) pay[k*16 +: 16] = 16'h5A00 ^ {4'd0, ln, 6'd0} ^ 16'(k);
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    if (!done) begin bad++; total++; $display("FAIL R12 no done pulse"); end
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset busy", 32'(busy), 0);
    chk("R12 reset done", 32'(done), 0);
    chk("R12 reset req", 32'(req), 0);
    rst_n = 1'b1;

    // R1 R2 R3 R5 R6: length sweep
    cfg_busy = 1; cfg_code = 4'h4;
    for (int l = 0; l <= 18; l++) begin
      run(2'd0, 6'(l + 3), 6'(l));
      if (l <= 16) begin
        chk("R1 R3 cmd word", 32'(cmd_log[0]), 32'({exp_par, 4'b0, 5'(l), 6'(l + 3)}));
        chk("R2 data writes", 32'(nwr), 32'(l / 2));
        for (int k = 0; k < l / 2; k++)
          chk("R2 data word", 32'(dmem[k]), 32'(16'h5A00 ^ {4'd0, 6'(l), 6'd0} ^ 16'(k)));
        chk("R5 success err", 32'(err), 0);
        exp_par = ~exp_par;
      end else begin
        chk("R6 bad len err", 32'(err), 1);
        chk("R6 no traffic", 32'(ncmd + nwr + nsts), 0);
      end
    end

    // R4: stale parity and transient codes are skipped
    cfg_stale = 2; cfg_busy = 3; cfg_rlen = 5'd6; cfg_code = 4'h4;
    run(2'd0, 6'h23, 6'd2);
    chk("R4 poll count", 32'(nsts), 6);
    chk("R4 R5 status word", 32'(sts), 32'({exp_par, 5'd6, 6'h23, 4'h4}));
    chk("R4 err", 32'(err), 0);
    exp_par = ~exp_par;

    // R5 R7: every final code
    cfg_stale = 0; cfg_busy = 0;
    for (int c = 0; c < 16; c++) begin
      cfg_code = 4'(c);
      cfg_hang = (c == 1 || c == 2 || c == 14);
      run(2'd0, 6'h15, 6'd0);
      if (cfg_hang) begin
        chk("R7 timeout err", 32'(err), 2);
        chk("R7 poll count", 32'(nsts), LIM);
      end else begin
        chk("R5 final code err", 32'(err), (c == 4) ? 0 : 3);
        chk("R5 single poll", 32'(nsts), 1);
      end
      exp_par = ~exp_par;
    end
    cfg_hang = 1'b0;

    // R8: post without polling
    run(2'd1, 6'h0A, 6'd4);
    chk("R8 cmd count", 32'(ncmd), 1);
    chk("R8 no status read", 32'(nsts), 0);
    chk("R8 err", 32'(err), 0);
    chk("R8 R3 parity", 32'(cmd_log[0][15]), 32'(exp_par));
    exp_par = ~exp_par;

    // R9 R10: reply read sweep
    for (int r = 0; r <= 17; r++) begin
      cfg_code = 4'h4; cfg_rlen = 5'(r);
      run(2'd0, 6'h01, 6'd2);
      exp_par = ~exp_par;
      run(2'd2, 6'h00, 6'd0);
      if (r <= 16) begin
        chk("R9 err", 32'(err), 0);
        chk("R9 words read", 32'(nrd), 32'((r + 1) / 2));
        chk("R9 count", 32'(rcnt), 32'((r + 1) / 2));
        for (int k = 0; k < 8; k++)
          chk("R9 reply word", 32'(rep[k*16 +: 16]),
              (k < (r + 1) / 2) ? 32'(16'hC300 + 16'(k) * 16'h0011) : 0);
      end else begin
        chk("R10 long reply err", 32'(err), 1);
        chk("R10 no traffic", 32'(nrd), 0);
      end
    end
    cfg_code = 4'h8; cfg_rlen = 5'd4;
    run(2'd0, 6'h01, 6'd0);
    exp_par = ~exp_par;
    run(2'd2, 6'h00, 6'd0);
    chk("R10 error status err", 32'(err), 3);
    chk("R10 error no traffic", 32'(nrd), 0);

    // R11: resync from both parity values
    for (int p = 0; p < 2; p++) begin
      if (exp_par != 1'(p)) begin
        cfg_code = 4'h4;
        run(2'd1, 6'h02, 6'd0);
        exp_par = ~exp_par;
      end
      cfg_code = 4'hF; cfg_busy = 2;
      run(2'd3, 6'h3F, 6'd8);
      chk("R11 two commands", 32'(ncmd), 2);
      chk("R11 first nop", 32'(cmd_log[0]), 32'({exp_par, 15'd0}));
      chk("R11 second nop", 32'(cmd_log[1]), 0);
      chk("R11 ready err", 32'(err), 0);
      exp_par = 1'b1;
      cfg_code = 4'h4; cfg_busy = 0;
      run(2'd0, 6'h02, 6'd0);
      chk("R11 R3 parity after sync", 32'(cmd_log[0][15]), 1);
      exp_par = 1'b0;
    end
    cfg_code = 4'h4;
    run(2'd3, 6'h00, 6'd0);
    chk("R11 not ready err", 32'(err), 4);

    @(negedge clk);
    chk("R12 idle after done", 32'(busy || done || req), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule